// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a clocked single-port memory. A command is registered on every active rising edge, and any mix of reads and writes can follow one another with no idle cycle between them. Read data is flow-through: it appears combinationally in the cycle that follows the edge that registered the read, with no output register. Write data is late: it is taken from the data input one active edge after the write address. It then waits in a one-entry posted-write stage and is committed to the array on the active edge after that. A read of an address that has a posted write returns the posted lanes merged over the array contents.

Each access begins a burst of up to four words. The advance input steps through the burst in linear or interleaved order. Writes are masked per 9-bit lane, and a write cycle with no lane enabled is an abort. A clock-enable input stalls the block. An output enable gates the read bus asynchronously. A sleep input freezes the block and keeps its contents. The array is a small parameterised register array that is cleared by reset.

Top module: `noturn_sram`

## Requirements
- R1: When `adv`=0 and all three selects are active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0), the edge starts an access at `addr`. `we_n`=0 starts a write and `we_n`=1 starts a read.
- R2: When `adv`=0 and any select is inactive, the edge deselects the block. A deselected block stays deselected on every `adv`=1 edge until an access begins.
- R3: When `adv`=1, the current burst steps to its next address. `addr`, `we_n` and the three selects have no effect on that edge.
- R4: Burst address n (n=0..3) keeps the upper address bits of the start address. With `lin_burst`=1 its two low bits are (start+n) mod 4. With `lin_burst`=0 they are start XOR n.
- R5: Write data is taken from `din` on the first active edge after the edge that registered the write address. It is committed to the array on the next active edge after that.
- R6: While a read is current, `rd_valid`=1 and the word at the current burst address is presented in that same cycle.
- R7: A read of the address held in the posted-write stage returns the posted data in its enabled lanes and the array contents in the other lanes.
- R8: `lane_en_n[i]`=0 writes bits [9i+8:9i] of the word. When every lane enable is 1 in a write cycle, no memory location changes.
- R9: While `clk_en`=0, an edge changes no state, captures no write data and leaves the outputs unchanged.
- R10: `dout_oe`=1 only when a read is current and `oe_n`=0. `oe_n` acts without waiting for a clock edge. `dout` is all zeros whenever `dout_oe`=0.
- R11: While `sleep`=1, edges are ignored, `rd_valid` and `dout_oe` are 0, and memory contents are kept. Operation resumes when `sleep` returns to 0. The edge before sleep is entered must not carry a selected write.
- R12: After reset the block is deselected, no write is posted, every word reads as zero, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 stalls the block |
| sleep | input | 1 | Low-power hold; freezes state and disables read outputs |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| we_n | input | 1 | 0 = write, 1 = read (when a command is loaded) |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Start address of an access |
| lin_burst | input | 1 | Burst order: 1 linear, 0 interleaved |
| din | input | LANES*LANE_W | Write data, one active edge after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Read data; zero when not driven |
| dout_oe | output | 1 | Read bus drive enable |
| rd_valid | output | 1 | Current cycle carries read data |

## Verification
Several properties are checked on every cycle. A deselect continues while advance is high. A posted write only ever follows a registered write. A stalled edge leaves all state frozen, and a loaded read makes `rd_valid` high on the next edge. Array words stay unchanged on cycles with no commit, and sleep is entered only after a non-write edge. The data-bearing behaviours can only be shown by the bench's scenarios, which compare every cycle against a reference model. These are the burst orders, the late-write timing, the merge of posted lanes into a read, write aborts, and contents kept across stalls and sleep.

// File: rtl/noturn_pkg.sv
package noturn_pkg;

    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits of burst step n from a start offset.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] n,
                                             input logic       linear);
        return linear ? 2'(start + n) : (start ^ n);
    endfunction

endpackage

// File: rtl/noturn_burst.sv
module noturn_burst #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    step,
    input  logic          linear,
    output logic [AW-1:0] cur_addr
);
    import noturn_pkg::*;

    always_comb begin
        cur_addr      = base;
        cur_addr[1:0] = burst_low(base[1:0], step, linear);
    end
endmodule

// File: rtl/noturn_array.sv
module noturn_array #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES-1:0]        wmask,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (we && wmask[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

    // R8: without a commit, a word read at an unchanged address stays put
    a_r8_idle_array_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (raddr != $past(raddr)) || $stable(rdata));
endmodule

// File: rtl/noturn_fwd.sv
module noturn_fwd #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] arr_data,
    input  logic [AW-1:0]           rd_addr,
    input  logic                    pend_valid,
    input  logic [AW-1:0]           pend_addr,
    input  logic [LANES-1:0]        pend_mask,
    input  logic [LANES*LANE_W-1:0] pend_data,
    output logic [LANES*LANE_W-1:0] merged
);
    logic hit;
    assign hit = pend_valid && (pend_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_mux
        assign merged[g*LANE_W +: LANE_W] = (hit && pend_mask[g])
            ? pend_data[g*LANE_W +: LANE_W]
            : arr_data[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/noturn_sram.sv
module noturn_sram #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    sleep,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    adv,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic [AW-1:0]           addr,
    input  logic                    lin_burst,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe,
    output logic                    rd_valid
);
    import noturn_pkg::*;

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        op_e              op;
        logic [AW-1:0]    base;
        logic [1:0]       step;
        logic [LANES-1:0] mask;
        logic             pv;
        logic [AW-1:0]    pa;
        logic [LANES-1:0] pm;
        logic [DW-1:0]    pd;
    } st_t;

    st_t st_q, st_d;

    logic          go;
    logic          sel_ok;
    logic [AW-1:0] cur_addr;
    logic          commit_we;
    logic [DW-1:0] arr_data;
    logic [DW-1:0] merged;

    assign go     = clk_en && !sleep;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    noturn_burst #(.AW(AW)) u_burst (
        .base     (st_q.base),
        .step     (st_q.step),
        .linear   (lin_burst),
        .cur_addr (cur_addr)
    );

    always_comb begin
        st_d      = st_q;
        commit_we = 1'b0;
        if (go) begin
            // posted write retires on this edge
            commit_we = st_q.pv;
            st_d.pv   = 1'b0;
            // late data of the registered write enters the posted stage
            if (st_q.op == OP_WRITE && |st_q.mask) begin
                st_d.pv = 1'b1;
                st_d.pa = cur_addr;
                st_d.pm = st_q.mask;
                st_d.pd = din;
            end
            if (!adv) begin
                if (sel_ok) begin
                    st_d.op   = we_n ? OP_READ : OP_WRITE;
                    st_d.base = addr;
                    st_d.step = 2'd0;
                    st_d.mask = ~lane_en_n;
                end else begin
                    st_d.op = OP_DESEL;
                end
            end else if (st_q.op != OP_DESEL) begin
                st_d.step = st_q.step + 2'd1;
                st_d.mask = ~lane_en_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    noturn_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit_we),
        .waddr (st_q.pa),
        .wmask (st_q.pm),
        .wdata (st_q.pd),
        .raddr (cur_addr),
        .rdata (arr_data)
    );

    noturn_fwd #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_fwd (
        .arr_data   (arr_data),
        .rd_addr    (cur_addr),
        .pend_valid (st_q.pv),
        .pend_addr  (st_q.pa),
        .pend_mask  (st_q.pm),
        .pend_data  (st_q.pd),
        .merged     (merged)
    );

    assign rd_valid = !sleep && (st_q.op == OP_READ);
    assign dout_oe  = rd_valid && !oe_n;
    assign dout     = dout_oe ? merged : '0;

    // R2: a deselect persists while advance is high
    a_r2_desel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (go && adv && st_q.op == OP_DESEL) |=> (st_q.op == OP_DESEL));

    // R5: a posted write appears only after a registered write command
    a_r5_post_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pv) |-> ($past(st_q.op) == OP_WRITE));

    // R9: a disabled clock edge freezes all state
    a_r9_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(st_q));

    // R6: a loaded read is flow-through on the next cycle
    a_r6_read_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !adv && sel_ok && we_n && !sleep) |=> (rd_valid || sleep));

    // R11: sleep is entered only after an edge without a selected write
    a_r11_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> $past(we_n || !sel_ok || adv));
endmodule

// File: tb/noturn_sram_test.sv
module noturn_sram_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int LANES = 2;
    localparam int LW = 9;
    localparam int DW = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b1, sleep = 1'b0;
    logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic adv = 1'b0, we_n = 1'b1, lin_burst = 1'b1, oe_n = 1'b0;
    logic [LANES-1:0] lane_en_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_oe, rd_valid;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R12";

    // reference model
    int            m_op;   // 0 idle, 1 read, 2 write
    int            m_base, m_step;
    logic [LANES-1:0] m_mask;
    bit            m_pv;
    int            m_pa;
    logic [LANES-1:0] m_pm;
    logic [DW-1:0] m_pd;
    logic [DW-1:0] m_mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    noturn_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .adv(adv),
        .we_n(we_n), .lane_en_n(lane_en_n), .addr(addr), .lin_burst(lin_burst),
        .din(din), .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe), .rd_valid(rd_valid)
    );

    function automatic int m_cur();
        int lo;
        lo = lin_burst ? ((m_base + m_step) % 4) : ((m_base % 4) ^ m_step);
        return (m_base & ~3) | lo;
    endfunction

    function automatic logic [DW-1:0] m_word(int a);
        logic [DW-1:0] w;
        w = m_mem[a];
        if (m_pv && m_pa == a)
            for (int l = 0; l < LANES; l++)
                if (m_pm[l]) w[l*LW +: LW] = m_pd[l*LW +: LW];
        return w;
    endfunction

    task automatic m_reset();
        m_op = 0; m_base = 0; m_step = 0; m_mask = '0;
        m_pv = 0; m_pa = 0; m_pm = '0; m_pd = '0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    endtask

    task automatic m_edge();
        int cur;
        if (!clk_en || sleep) return;
        cur = m_cur();
        if (m_pv)
            for (int l = 0; l < LANES; l++)
                if (m_pm[l]) m_mem[m_pa][l*LW +: LW] = m_pd[l*LW +: LW];
        if (m_op == 2 && m_mask != 0) begin
            m_pv = 1; m_pa = cur; m_pm = m_mask; m_pd = din;
        end else m_pv = 0;
        if (!adv) begin
            if (!sel_a_n && sel_b && !sel_c_n) begin
                m_op = we_n ? 1 : 2; m_base = addr; m_step = 0; m_mask = ~lane_en_n;
            end else m_op = 0;
        end else if (m_op != 0) begin
            m_step = (m_step + 1) % 4; m_mask = ~lane_en_n;
        end
    endtask

    task automatic compare();
        logic          e_rv, e_oe;
        logic [DW-1:0] e_d;
        e_rv = !sleep && (m_op == 1);
        e_oe = e_rv && !oe_n;
        e_d  = e_oe ? m_word(m_cur()) : '0;
        n_cmp++;
        if (rd_valid !== e_rv || dout_oe !== e_oe || dout !== e_d) begin
            n_bad++;
            $display("FAIL %s t=%0t got rv=%b oe=%b d=%h expected rv=%b oe=%b d=%h",
                     cur_req, $time, rd_valid, dout_oe, dout, e_rv, e_oe, e_d);
        end
    endtask

    task automatic tick();
        din = DW'($urandom());
        @(posedge clk);
        m_edge();
        #1 compare();
        @(negedge clk);
    endtask

    task automatic begin_op(bit wr, int a, logic [LANES-1:0] ln);
        clk_en = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0; adv = 0;
        we_n = !wr; addr = AW'(a); lane_en_n = ln;
        tick();
    endtask

    // continue: address, write enable and selects scrambled (R3)
    task automatic cont(logic [LANES-1:0] ln);
        clk_en = 1; adv = 1; lane_en_n = ln;
        addr = AW'($urandom()); we_n = 1'($urandom());
        sel_a_n = 1'($urandom()); sel_b = 1'($urandom()); sel_c_n = 1'($urandom());
        tick();
    endtask

    task automatic desel(int which);
        clk_en = 1; adv = 0; we_n = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        case (which)
            0: sel_a_n = 1;
            1: sel_b = 0;
            default: sel_c_n = 1;
        endcase
        tick();
    endtask

    task automatic stall(int n);
        for (int i = 0; i < n; i++) begin
            clk_en = 0; adv = 1'($urandom()); we_n = 1'($urandom());
            addr = AW'($urandom()); lane_en_n = LANES'($urandom());
            tick();
        end
        clk_en = 1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_reset();
        cur_req = "R12";
        repeat (3) @(negedge clk);
        #1 compare();
        rst_n = 1;
        @(negedge clk);
        desel(0); desel(1);

        cur_req = "R1";
        begin_op(1, 5, 2'b00);
        cur_req = "R5";
        desel(2); desel(0);
        cur_req = "R6";
        begin_op(0, 5, 2'b00);
        begin_op(0, 4, 2'b00);

        cur_req = "R7";
        begin_op(1, 9, 2'b00);
        begin_op(0, 9, 2'b00);
        begin_op(1, 10, 2'b10);
        begin_op(0, 10, 2'b00);
        begin_op(0, 10, 2'b00);

        cur_req = "R4";
        lin_burst = 1;
        begin_op(1, 14, 2'b00); cont(2'b00); cont(2'b00); cont(2'b00);
        begin_op(0, 14, 2'b00); cont(2'b00); cont(2'b00); cont(2'b00);
        lin_burst = 0;
        begin_op(0, 13, 2'b00); cont(2'b00); cont(2'b00); cont(2'b00);
        begin_op(1, 22, 2'b00); cont(2'b00); cont(2'b00); cont(2'b00);
        cur_req = "R3";
        begin_op(0, 21, 2'b00); cont(2'b00); cont(2'b00); cont(2'b00); cont(2'b00);

        cur_req = "R8";
        begin_op(1, 5, 2'b11); begin_op(0, 5, 2'b00); begin_op(0, 5, 2'b00);
        begin_op(1, 5, 2'b01); desel(0); begin_op(0, 5, 2'b00);
        begin_op(1, 30, 2'b00); cont(2'b11); cont(2'b10); desel(1);
        begin_op(0, 30, 2'b00); cont(2'b00); cont(2'b00);

        cur_req = "R2";
        begin_op(0, 9, 2'b00); desel(1);
        cont(2'b00); cont(2'b00);
        adv = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0; we_n = 1; tick();
        desel(2); desel(0);

        cur_req = "R9";
        begin_op(0, 14, 2'b00); stall(3); cont(2'b00);
        begin_op(1, 40, 2'b00); stall(2);
        begin_op(0, 40, 2'b00); stall(2); begin_op(0, 40, 2'b00);

        cur_req = "R10";
        begin_op(0, 9, 2'b00);
        oe_n = 1; #1 compare();
        oe_n = 0; #1 compare();
        oe_n = 1; tick(); oe_n = 0; tick();

        cur_req = "R11";
        begin_op(1, 50, 2'b00);
        begin_op(0, 50, 2'b00);
        desel(0);
        sleep = 1; #1 compare();
        for (int i = 0; i < 4; i++) begin
            adv = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
            we_n = 1'($urandom()); addr = AW'($urandom());
            lane_en_n = '0; tick();
        end
        adv = 0; we_n = 1; sel_a_n = 1; tick();
        sleep = 0;
        begin_op(0, 50, 2'b00);
        begin_op(0, 9, 2'b00);

        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            clk_en    = ($urandom() % 10) != 0;
            adv       = ($urandom() % 3) == 0;
            sel_a_n   = ($urandom() % 8) == 0;
            sel_b     = ($urandom() % 8) != 0;
            sel_c_n   = ($urandom() % 8) == 0;
            we_n      = 1'($urandom());
            lane_en_n = LANES'($urandom());
            addr      = AW'($urandom() % 16);
            lin_burst = 1'($urandom());
            oe_n      = ($urandom() % 6) == 0;
            tick();
        end
        finish_run();
    end
endmodule